// File: doc/BRIEF.md
# Flash Power-Up Instruction Gate

This block sits at the front of a serial NOR flash command path and decides, from two digitised supply flags, when the device may respond to instructions. One flag says the supply is above the write-inhibit threshold. The other says it is above the minimum operating level. While the first flag is low, the whole block is held in reset and every instruction is refused.

Two delay counters, each measured in clock cycles, release instructions in two stages. The select-allow delay starts when the operating-level flag rises. When it ends, reads and other harmless instructions are accepted. The write-inhibit delay starts when the threshold flag rises. Instructions that can change the array or the status register are refused until both delays have ended.

For every valid opcode strobe the block either accepts the instruction or raises a one-cycle ignore pulse. An accepted write-enable instruction sets the write-enable latch. The latch comes out of power-up cleared, and the device comes out of power-up in standby rather than in deep power-down.

Top module: `pwrup_gate`

## Requirements
- R1: While `inhibitOk` is low, `coreReset` is high and `readOk`, `writeOk`, `opAccept` and `welState` are all low, in the same cycle that the flag is low.
- R2: With `inhibitOk` high, `readOk` rises after SELECT_CYC rising clock edges (default 8) at which `vccOk` has been continuously high, and not before.
- R3: `writeOk` rises only once `inhibitOk` has been high for INHIBIT_CYC rising edges (default 16) and `readOk` is also high.
- R4: The write-class opcodes 0x06, 0x02, 0x20, 0xD8, 0xC7 and 0x01 are accepted only while `writeOk` is high.
- R5: While `readOk` is high, any valid opcode outside the write class, including read 0x03, is accepted.
- R6: After power-up `welState` is 0. An accepted opcode 0x06 sets it at the next rising edge, and nothing else sets it.
- R7: `opIgnored` is high exactly in the cycles where `opValid` is high and the instruction is not accepted. It is never high at the same time as `opAccept`.
- R8: When `inhibitOk` falls during operation, the permits and the latch drop in the same cycle. When the flag recovers, both delays count again from zero.
- R9: When `vccOk` falls while `inhibitOk` stays high, `readOk` and `writeOk` drop in the same cycle. The select-allow delay restarts on the next rise of `vccOk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| inhibitOk | input | 1 | Supply is above the write-inhibit threshold; low holds the block in reset |
| vccOk | input | 1 | Supply is above the minimum operating level |
| opValid | input | 1 | Decoded opcode strobe, one cycle per instruction |
| opCode | input | 8 | Decoded instruction opcode |
| coreReset | output | 1 | Global reset for the rest of the front end |
| readOk | output | 1 | Read-class instructions are permitted |
| writeOk | output | 1 | Write-class instructions are permitted |
| opAccept | output | 1 | The current valid instruction is accepted |
| opIgnored | output | 1 | The current valid instruction is refused |
| welState | output | 1 | Write-enable latch |

## Verification
The hardest case to reach is the window in which reads are already permitted but the write-inhibit delay is still running. In that window a write-class opcode must be refused while a read is accepted. The bench raises both supply flags together and sends each of the six write-class opcodes during the cycles between the eighth and sixteenth edges. It also holds `vccOk` low long past the write-inhibit delay, to show that write permission then waits on the select-allow delay. Drop-and-recover sequences on each flag show that the matching counter restarts from zero.

// File: rtl/pwrup_gate_pkg.sv
package pwrup_gate_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_BE   = 8'hD8;
  localparam logic [7:0] OP_CE   = 8'hC7;
  localparam logic [7:0] OP_WRSR = 8'h01;

  typedef struct packed {
    logic clrInhibit;
    logic clrSelect;
    logic setWel;
  } gateStrobe_t;

  function automatic logic isWriteClass(input logic [7:0] op);
    return (op == OP_WREN) || (op == OP_PP) || (op == OP_SE) ||
           (op == OP_BE) || (op == OP_CE) || (op == OP_WRSR);
  endfunction
endpackage

// File: rtl/pwrup_delay_cnt.sv
module pwrup_delay_cnt #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic clr,
  output logic done
);
  localparam int unsigned W = $clog2(CYCLES + 1);
  logic [W-1:0] cnt;

  assign done = (cnt == W'(CYCLES));

  always_ff @(posedge clk) begin
    if (clr) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwrup_gate_dp.sv
module pwrup_gate_dp
  import pwrup_gate_pkg::*;
#(
  parameter int unsigned INHIBIT_CYC = 16,
  parameter int unsigned SELECT_CYC  = 8
) (
  input  logic        clk,
  input  gateStrobe_t strobe,
  output logic        inhibitDone,
  output logic        selectDone,
  output logic        welState
);
  logic welQ;

  pwrup_delay_cnt #(.CYCLES(INHIBIT_CYC)) u_inhibitCnt (
    .clk(clk), .clr(strobe.clrInhibit), .done(inhibitDone)
  );

  pwrup_delay_cnt #(.CYCLES(SELECT_CYC)) u_selectCnt (
    .clk(clk), .clr(strobe.clrSelect), .done(selectDone)
  );

  always_ff @(posedge clk) begin
    if (strobe.clrInhibit) welQ <= 1'b0;
    else if (strobe.setWel) welQ <= 1'b1;
  end

  assign welState = welQ && !strobe.clrInhibit;
endmodule

// File: rtl/pwrup_gate_ctl.sv
module pwrup_gate_ctl
  import pwrup_gate_pkg::*;
(
  input  logic        inhibitOk,
  input  logic        vccOk,
  input  logic        opValid,
  input  logic [7:0]  opCode,
  input  logic        inhibitDone,
  input  logic        selectDone,
  output gateStrobe_t strobe,
  output logic        readOk,
  output logic        writeOk,
  output logic        opAccept,
  output logic        opIgnored
);
  logic opIsWrite;

  always_comb begin
    opIsWrite = isWriteClass(opCode);
    readOk    = inhibitOk && vccOk && selectDone;
    writeOk   = readOk && inhibitDone;
    opAccept  = opValid && readOk && (!opIsWrite || writeOk);
    opIgnored = opValid && !opAccept;

    strobe.clrInhibit = !inhibitOk;
    strobe.clrSelect  = !inhibitOk || !vccOk;
    strobe.setWel     = opAccept && (opCode == OP_WREN);
  end
endmodule

// File: rtl/pwrup_gate.sv
module pwrup_gate
  import pwrup_gate_pkg::*;
#(
  parameter int unsigned INHIBIT_CYC = 16,
  parameter int unsigned SELECT_CYC  = 8
) (
  input  logic       clk,
  input  logic       inhibitOk,
  input  logic       vccOk,
  input  logic       opValid,
  input  logic [7:0] opCode,
  output logic       coreReset,
  output logic       readOk,
  output logic       writeOk,
  output logic       opAccept,
  output logic       opIgnored,
  output logic       welState
);
  gateStrobe_t strobe;
  logic inhibitDone;
  logic selectDone;

  assign coreReset = !inhibitOk;

  pwrup_gate_ctl u_ctl (
    .inhibitOk(inhibitOk), .vccOk(vccOk), .opValid(opValid), .opCode(opCode),
    .inhibitDone(inhibitDone), .selectDone(selectDone), .strobe(strobe),
    .readOk(readOk), .writeOk(writeOk), .opAccept(opAccept), .opIgnored(opIgnored)
  );

  pwrup_gate_dp #(.INHIBIT_CYC(INHIBIT_CYC), .SELECT_CYC(SELECT_CYC)) u_dp (
    .clk(clk), .strobe(strobe), .inhibitDone(inhibitDone),
    .selectDone(selectDone), .welState(welState)
  );
endmodule

// File: rtl/pwrup_gate_chk.sv
module pwrup_gate_chk #(
  parameter int unsigned INHIBIT_CYC = 16,
  parameter int unsigned SELECT_CYC  = 8
) (
  input logic       clk,
  input logic       inhibitOk,
  input logic       vccOk,
  input logic       opValid,
  input logic [7:0] opCode,
  input logic       coreReset,
  input logic       readOk,
  input logic       writeOk,
  input logic       opAccept,
  input logic       opIgnored,
  input logic       welState
);
  int unsigned ihSeen;
  int unsigned vsSeen;
  logic wrOp;

  assign wrOp = (opCode == 8'h06) || (opCode == 8'h02) || (opCode == 8'h20) ||
                (opCode == 8'hD8) || (opCode == 8'hC7) || (opCode == 8'h01);

  always_ff @(posedge clk) begin
    if (!inhibitOk) ihSeen <= 0;
    else if (ihSeen < INHIBIT_CYC) ihSeen <= ihSeen + 1;
    if (!inhibitOk || !vccOk) vsSeen <= 0;
    else if (vsSeen < SELECT_CYC) vsSeen <= vsSeen + 1;
  end

  assert_hold_in_reset_R1: assert property (@(posedge clk)
    !inhibitOk |-> coreReset && !readOk && !writeOk && !opAccept && !welState);

  assert_read_delay_R2: assert property (@(posedge clk) disable iff (!inhibitOk)
    readOk == (vccOk && vsSeen >= SELECT_CYC));

  assert_write_delay_R3: assert property (@(posedge clk) disable iff (!inhibitOk)
    writeOk |-> readOk && ihSeen >= INHIBIT_CYC);

  assert_write_opcode_gate_R4: assert property (@(posedge clk) disable iff (!inhibitOk)
    opValid && wrOp && !writeOk |-> !opAccept);

  assert_other_opcode_pass_R5: assert property (@(posedge clk) disable iff (!inhibitOk)
    opValid && !wrOp && readOk |-> opAccept);

  assert_wel_set_R6: assert property (@(posedge clk) disable iff (!inhibitOk)
    opAccept && opCode == 8'h06 |=> welState);

  assert_wel_source_R6: assert property (@(posedge clk) disable iff (!inhibitOk)
    $rose(welState) |-> $past(opAccept && opCode == 8'h06));

  assert_ignore_pulse_R7: assert property (@(posedge clk)
    !(opIgnored && opAccept) && (opIgnored || opAccept) == opValid);

  assert_vcc_drop_R9: assert property (@(posedge clk) disable iff (!inhibitOk)
    !vccOk |-> !readOk && !writeOk);
endmodule

bind pwrup_gate pwrup_gate_chk #(.INHIBIT_CYC(INHIBIT_CYC), .SELECT_CYC(SELECT_CYC)) u_chk (
  .clk(clk), .inhibitOk(inhibitOk), .vccOk(vccOk), .opValid(opValid), .opCode(opCode),
  .coreReset(coreReset), .readOk(readOk), .writeOk(writeOk), .opAccept(opAccept),
  .opIgnored(opIgnored), .welState(welState)
);

// File: tb/pwrup_gate_bench.sv
module pwrup_gate_bench;
  logic clk = 1'b0;
  logic inhibitOk = 1'b0;
  logic vccOk = 1'b0;
  logic opValid = 1'b0;
  logic [7:0] opCode = 8'h00;
  logic coreReset, readOk, writeOk, opAccept, opIgnored, welState;
  int nChecks = 0;
  int nFails = 0;
  logic [7:0] wrOps [6] = '{8'h06, 8'h02, 8'h20, 8'hD8, 8'hC7, 8'h01};

  always #2.5 clk = ~clk;

  pwrup_gate u_pwrup_gate (
    .clk(clk), .inhibitOk(inhibitOk), .vccOk(vccOk), .opValid(opValid), .opCode(opCode),
    .coreReset(coreReset), .readOk(readOk), .writeOk(writeOk), .opAccept(opAccept),
    .opIgnored(opIgnored), .welState(welState)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Presents one opcode for a cycle; returns accept/ignore seen mid-cycle.
  task automatic sendOp(input logic [7:0] op, input string req, input int expAcc);
    opCode = op; opValid = 1'b1;
    #0.5;
    chk({req, " accept"}, int'(opAccept), expAcc);
    chk({req, " ignored"}, int'(opIgnored), 1 - expAcc);
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic powerOff();
    inhibitOk = 1'b0; vccOk = 1'b0;
    edges(3);
  endtask

  task automatic t_reset();
    vccOk = 1'b1;
    edges(2);
    chk("R1 coreReset", int'(coreReset), 1);
    chk("R1 readOk", int'(readOk), 0);
    chk("R1 writeOk", int'(writeOk), 0);
    chk("R1 wel", int'(welState), 0);
    sendOp(8'h06, "R1 wren in reset", 0);
    sendOp(8'h03, "R7 read in reset", 0);
    chk("R1 wel after wren", int'(welState), 0);
    powerOff();
  endtask

  task automatic t_powerup();
    inhibitOk = 1'b1; vccOk = 1'b1;
    edges(1);
    chk("R6 wel after power-up", int'(welState), 0);
    chk("R1 coreReset released", int'(coreReset), 0);
    edges(6);
    chk("R2 readOk at 7", int'(readOk), 0);
    sendOp(8'h03, "R2 read before delay", 0);   // consumes edge 8
    chk("R2 readOk at 8", int'(readOk), 1);
    sendOp(8'h03, "R5 read", 1);                // edge 9
    sendOp(8'h9F, "R5 other opcode", 1);        // edge 10
    for (int i = 0; i < 5; i++) sendOp(wrOps[i], "R4 write-class in read window", 0); // 11..15
    chk("R3 writeOk at 15", int'(writeOk), 0);
    chk("R6 wel stays clear", int'(welState), 0);
    sendOp(wrOps[5], "R4 wrsr in read window", 0); // edge 16
    chk("R3 writeOk at 16", int'(writeOk), 1);
    sendOp(8'h06, "R4 wren accepted", 1);
    chk("R6 wel set", int'(welState), 1);
    for (int i = 1; i < 6; i++) sendOp(wrOps[i], "R4 write-class accepted", 1);
  endtask

  task automatic t_inhibitDrop();
    inhibitOk = 1'b0;
    #0.5;
    chk("R8 readOk drops at once", int'(readOk), 0);
    chk("R8 wel drops at once", int'(welState), 0);
    sendOp(8'h03, "R8 read while dropped", 0);
    inhibitOk = 1'b1;
    edges(7);
    chk("R8 read restarts", int'(readOk), 0);
    edges(1);
    chk("R8 read after restart", int'(readOk), 1);
    chk("R8 wel cleared", int'(welState), 0);
    edges(7);
    chk("R8 write restarts at 15", int'(writeOk), 0);
    edges(1);
    chk("R8 write after restart", int'(writeOk), 1);
  endtask

  task automatic t_vccDrop();
    sendOp(8'h06, "R6 wren", 1);
    vccOk = 1'b0;
    #0.5;
    chk("R9 readOk drops", int'(readOk), 0);
    chk("R9 writeOk drops", int'(writeOk), 0);
    chk("R9 wel kept", int'(welState), 1);
    edges(5);
    vccOk = 1'b1;
    edges(7);
    chk("R9 read restarts", int'(readOk), 0);
    edges(1);
    chk("R9 read back", int'(readOk), 1);
    chk("R9 write back", int'(writeOk), 1);
  endtask

  task automatic t_vccLate();
    powerOff();
    inhibitOk = 1'b1;
    edges(25);
    chk("R3 write waits for select delay", int'(writeOk), 0);
    sendOp(8'h03, "R2 read without vcc", 0);
    vccOk = 1'b1;
    edges(7);
    chk("R3 write still off", int'(writeOk), 0);
    edges(1);
    chk("R3 write with both delays", int'(writeOk), 1);
    chk("R2 read with vcc", int'(readOk), 1);
  endtask

  initial begin
    edges(2);
    t_reset();
    t_powerup();
    t_inhibitDrop();
    t_vccDrop();
    t_vccLate();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule